// File: doc/BRIEF.md
# Iterative Multiply/Divide Coprocessor

This block is a small arithmetic unit that a host drives through byte-wide write and read registers. It computes an unsigned 8x8 product one multiplier bit per clock, taking eight cycles. It computes an unsigned 16/8 quotient and remainder one dividend bit per clock, taking sixteen cycles. The datapath is built from shift-and-add and restoring shift-and-subtract steps. Writing the multiplier register starts a multiply, and writing the divisor register starts a divide. A `busy` output tells the host when the results are final.

Operand writes have side effects on the result registers, even when the write cannot start an operation. A start request that arrives while either operation is running is discarded, and the operation already running carries on. A zero divisor does not trap. It produces a fixed pattern instead.

Top module: `muldiv_coproc`

## Requirements
- R1: A write with `wr_sel`=0 stores the multiplicand byte. It starts no operation and changes neither result register. A multiplicand written while a multiply runs does not alter that multiply's product.
- R2: A write with `wr_sel`=1 (multiplier) made while idle starts a multiply. Once `busy` falls, the product register holds multiplicand*multiplier as a 16-bit value.
- R3: Every multiplier write clears the product/remainder register to zero on the same edge, whether or not it is accepted.
- R4: A multiplier or divisor write made while `busy` is high changes no operand and starts nothing. The running operation finishes with its original operands.
- R5: An accepted multiplier write loads the quotient register with {multiplier, multiplicand}, and the quotient register keeps that value for the whole multiply.
- R6: A write with `wr_sel`=2 replaces only the low dividend byte, and a write with `wr_sel`=3 replaces only the high byte. Neither write starts anything.
- R7: Every divisor write (`wr_sel`=4) loads the product/remainder register with the current 16-bit dividend on the same edge.
- R8: An accepted divisor write starts a divide. Once `busy` falls, the quotient register holds dividend/divisor and the product/remainder register holds dividend mod divisor.
- R9: With a divisor of zero, the divide still takes sixteen cycles. It ends with a quotient of 0xFFFF and a remainder equal to the dividend.
- R10: `rd_sel` values 0, 1, 2 and 3 return the quotient low byte, the quotient high byte, the product/remainder low byte and the product/remainder high byte, in that order, combinationally.
- R11: `busy` rises in the cycle after an accepted start. It stays high for exactly 8 cycles for a multiply and 16 cycles for a divide, and a start written in the first cycle it is low is accepted.
- R12: After reset every result byte reads zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one register this cycle |
| wr_sel | input | 3 | Write register select (0 multiplicand, 1 multiplier, 2 dividend low, 3 dividend high, 4 divisor; others ignored) |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 2 | Read byte select |
| rd_data | output | 8 | Selected result byte |
| busy | output | 1 | An operation is iterating |

## Verification
The bench goes after these corner cases:
- **Operand extremes.** The bench uses operands 0, 1 and 255, and the dividends 0xFFFF and 0. A datapath with a carry or width fault would return a truncated product or a remainder at or above the divisor.
- **Dropped starts.** Divisor and multiplier writes arrive partway through a divide. A design that accepted them would end with the wrong quotient or stop early.
- **Clear on every write.** The bench samples the product/remainder register in the cycle right after each multiplier or divisor write. A design that applied the clear or dividend load only to accepted writes would show the stale value.
- **Zero divisor and start boundary.** The bench divides by zero and checks for 0xFFFF and the dividend. It also starts a new operation in the first idle cycle, which catches an off-by-one `busy` window.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    // Write register select codes (host-visible map)
    localparam logic [2:0] SEL_MCAND  = 3'd0;
    localparam logic [2:0] SEL_MPLIER = 3'd1;
    localparam logic [2:0] SEL_DVD_LO = 3'd2;
    localparam logic [2:0] SEL_DVD_HI = 3'd3;
    localparam logic [2:0] SEL_DVSR   = 3'd4;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } op_e;

    typedef struct packed {
        logic mcand;
        logic mplier;
        logic dvd_lo;
        logic dvd_hi;
        logic dvsr;
    } wr_strb_t;

endpackage

// File: rtl/muldiv_wr_decode.sv
module muldiv_wr_decode
    import muldiv_pkg::*;
(
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    output wr_strb_t   strb
);
    always_comb begin
        strb        = '0;
        strb.mcand  = wr_en && (wr_sel == SEL_MCAND);
        strb.mplier = wr_en && (wr_sel == SEL_MPLIER);
        strb.dvd_lo = wr_en && (wr_sel == SEL_DVD_LO);
        strb.dvd_hi = wr_en && (wr_sel == SEL_DVD_HI);
        strb.dvsr   = wr_en && (wr_sel == SEL_DVSR);
    end
endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine
    import muldiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_strb_t     strb,
    input  logic [W-1:0] wr_data,
    output logic [2*W-1:0] quo,
    output logic [2*W-1:0] prm,
    output logic         busy
);
    localparam int DW        = 2 * W;
    localparam int MUL_STEPS = W;
    localparam int DIV_STEPS = DW;
    localparam int CW        = $clog2(DIV_STEPS + 1);

    typedef struct packed {
        logic [W-1:0]  mcand;
        logic [W-1:0]  mplier;
        logic [W-1:0]  dvsr;
        logic [DW-1:0] dvd;
        logic [DW-1:0] quo;
        logic [DW-1:0] prm;
        logic [DW-1:0] addend;
        logic [W-1:0]  mshift;
        logic [W-1:0]  rem;
        logic [CW-1:0] cnt;
        op_e           op;
    } eng_s;

    eng_s st_d, st_q;

    logic         busy_q;
    logic [W:0]   trial;
    logic         fits;

    assign busy_q = (st_q.cnt != '0);

    always_comb begin
        st_d  = st_q;
        trial = {st_q.rem, st_q.quo[DW-1]};
        fits  = (trial >= {1'b0, st_q.dvsr});

        // one iteration step
        if (busy_q) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.op == OP_MUL) begin
                if (st_q.mshift[0]) begin
                    st_d.prm = st_q.prm + st_q.addend;
                end
                st_d.addend = st_q.addend << 1;
                st_d.mshift = st_q.mshift >> 1;
            end else begin
                st_d.quo = {st_q.quo[DW-2:0], fits};
                st_d.rem = fits ? W'(trial - {1'b0, st_q.dvsr}) : trial[W-1:0];
                if (st_q.dvsr != '0) begin
                    st_d.prm = {{W{1'b0}}, st_d.rem};
                end
            end
        end

        // host writes override the iteration
        if (strb.mcand) begin
            st_d.mcand = wr_data;
        end
        if (strb.dvd_lo) begin
            st_d.dvd[W-1:0] = wr_data;
        end
        if (strb.dvd_hi) begin
            st_d.dvd[DW-1:W] = wr_data;
        end
        if (strb.mplier) begin
            st_d.prm = '0;
            if (!busy_q) begin
                st_d.mplier = wr_data;
                st_d.quo    = {wr_data, st_q.mcand};
                st_d.addend = {{W{1'b0}}, st_q.mcand};
                st_d.mshift = wr_data;
                st_d.cnt    = CW'(MUL_STEPS);
                st_d.op     = OP_MUL;
            end
        end
        if (strb.dvsr) begin
            st_d.prm = st_q.dvd;
            if (!busy_q) begin
                st_d.dvsr = wr_data;
                st_d.quo  = st_q.dvd;
                st_d.rem  = '0;
                st_d.cnt  = CW'(DIV_STEPS);
                st_d.op   = OP_DIV;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{default: '0, op: OP_MUL};
        end else begin
            st_q <= st_d;
        end
    end

    assign quo  = st_q.quo;
    assign prm  = st_q.prm;
    assign busy = busy_q;

    // R3: any multiplier write leaves the product register at zero
    a_r3_prm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        strb.mplier |=> (st_q.prm == '0));

    // R7: any divisor write loads the dividend into product/remainder
    a_r7_prm_dividend: assert property (@(posedge clk) disable iff (!rst_n)
        strb.dvsr |=> (st_q.prm == $past(st_q.dvd)));

    // R4: a divisor write while busy leaves the divisor unchanged
    a_r4_dvsr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.dvsr && busy_q) |=> $stable(st_q.dvsr));

    // R4: a multiplier write while busy leaves the multiplier unchanged
    a_r4_mplier_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.mplier && busy_q) |=> $stable(st_q.mplier));

    // R5: accepted multiply loads {multiplier, multiplicand}
    a_r5_quo_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.mplier && !busy_q) |=> (st_q.quo == {$past(wr_data), $past(st_q.mcand)}));

    // R11: an accepted start raises busy on the next cycle
    a_r11_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((strb.mplier || strb.dvsr) && !busy_q) |=> busy_q);

    // R9: a zero-divisor divide ends with an all-ones quotient
    a_r9_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && st_q.op == OP_DIV && st_q.dvsr == '0) |-> (st_q.quo == '1));

endmodule

// File: rtl/muldiv_rd_mux.sv
module muldiv_rd_mux #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] quo,
    input  logic [2*W-1:0] prm,
    input  logic [1:0]     rd_sel,
    output logic [W-1:0]   rd_data
);
    logic [2*W-1:0] word;

    always_comb begin
        word    = rd_sel[1] ? prm : quo;
        rd_data = rd_sel[0] ? word[2*W-1:W] : word[W-1:0];
    end
endmodule

// File: rtl/muldiv_coproc.sv
module muldiv_coproc
    import muldiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic         busy
);
    localparam int DW = 2 * W;

    wr_strb_t      strb;
    logic [DW-1:0] quo;
    logic [DW-1:0] prm;

    muldiv_wr_decode u_dec (
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .strb   (strb)
    );

    muldiv_engine #(.W(W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (strb),
        .wr_data (wr_data),
        .quo     (quo),
        .prm     (prm),
        .busy    (busy)
    );

    muldiv_rd_mux #(.W(W)) u_rd (
        .quo     (quo),
        .prm     (prm),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );
endmodule

// File: tb/muldiv_coproc_tb.sv
`timescale 1ns/1ps
module muldiv_coproc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R12";

    always #2.5 clk = ~clk;

    muldiv_coproc dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy)
    );

    // behavioural reference
    int          m_cnt;
    bit          m_mul;
    logic [7:0]  m_a, m_b, m_dvs;
    logic [15:0] m_dvd, m_quo, m_prm;
    bit          m_clr0, m_ld;
    logic [15:0] m_ldval;

    always @(posedge clk) begin
        bit idle;
        m_clr0 = 0;
        m_ld   = 0;
        if (!rst_n) begin
            m_cnt = 0; m_mul = 0; m_a = 0; m_b = 0; m_dvs = 0;
            m_dvd = 0; m_quo = 0; m_prm = 0;
        end else begin
            idle = (m_cnt == 0);
            if (!idle) m_cnt = m_cnt - 1;
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_a = wr_data;
                    3'd1: begin
                        m_clr0 = 1;
                        if (idle) begin
                            m_b = wr_data; m_quo = {wr_data, m_a};
                            m_prm = 16'(m_a * wr_data); m_cnt = 8; m_mul = 1;
                        end
                    end
                    3'd2: m_dvd[7:0] = wr_data;
                    3'd3: m_dvd[15:8] = wr_data;
                    3'd4: begin
                        m_ld = 1; m_ldval = m_dvd;
                        if (idle) begin
                            m_dvs = wr_data; m_cnt = 16; m_mul = 0;
                            if (wr_data == 0) begin
                                m_quo = 16'hFFFF; m_prm = m_dvd;
                            end else begin
                                m_quo = m_dvd / wr_data; m_prm = m_dvd % wr_data;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic [7:0] b [4];
        @(posedge clk);
        #0.5;
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #0.3;
            b[s] = rd_data;
        end
        chk("R11 busy", {15'd0, busy}, {15'd0, m_cnt != 0});
        if (m_clr0) chk("R3 prm cleared", {b[3], b[2]}, 16'h0);
        else if (m_ld) chk("R7 prm dividend", {b[3], b[2]}, m_ldval);
        if (m_cnt == 0) begin
            chk({tag, "/R10 quotient"}, {b[1], b[0]}, m_quo);
            chk({tag, "/R10 prod-rem"}, {b[3], b[2]}, m_prm);
        end else if (m_mul) begin
            chk("R5 quotient pair", {b[1], b[0]}, m_quo);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic do_mul(logic [7:0] a, logic [7:0] b);
        wr(3'd0, a); wr(3'd1, b);
        repeat (8) tick();
    endtask

    task automatic do_div(logic [15:0] n, logic [7:0] d);
        wr(3'd2, n[7:0]); wr(3'd3, n[15:8]); wr(3'd4, d);
        repeat (16) tick();
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tag = "R12";
        repeat (2) tick();

        tag = "R1";
        wr(3'd0, 8'h5A);
        repeat (3) tick();

        tag = "R2";
        do_mul(8'd13, 8'd11);
        do_mul(8'd255, 8'd255);
        do_mul(8'd0, 8'd77);
        do_mul(8'd1, 8'd1);
        do_mul(8'd200, 8'd0);

        tag = "R1";  // multiplicand written mid-multiply
        wr(3'd0, 8'd9); wr(3'd1, 8'd7);
        repeat (3) tick();
        wr(3'd0, 8'd250);
        repeat (5) tick();

        tag = "R11"; // restart in the first idle cycle
        wr(3'd0, 8'd3); wr(3'd1, 8'd5);
        repeat (8) tick();
        wr(3'd1, 8'd6);
        repeat (8) tick();

        tag = "R8";
        do_div(16'hFFFF, 8'd255);
        do_div(16'd1000, 8'd7);
        do_div(16'd5, 8'd9);
        do_div(16'd0, 8'd3);
        do_div(16'hBEEF, 8'd1);

        tag = "R9";
        do_div(16'h1234, 8'd0);

        tag = "R6";
        wr(3'd2, 8'h10);
        wr(3'd4, 8'd16);
        repeat (16) tick();

        tag = "R4";
        do_div(16'd50000, 8'd123);
        wr(3'd4, 8'd200);
        repeat (3) tick();
        wr(3'd4, 8'd3);
        repeat (2) tick();
        wr(3'd1, 8'd99);
        repeat (10) tick();

        tag = "R2";
        for (int i = 0; i < 20; i++) begin
            do_mul(8'($urandom), 8'($urandom));
        end
        tag = "R8";
        for (int i = 0; i < 20; i++) begin
            do_div(16'($urandom), 8'($urandom_range(1, 255)));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule